// File: doc/BRIEF.md
# I2C Single-Master Byte Engine

This block is the only master on a two-wire I2C bus. It generates SCL from a programmable divider and runs exactly one bus event per command. There are six events: a Start condition, a Repeated Start, a Stop condition, sending one byte, receiving one byte, and driving the acknowledge bit that follows a received byte. Control logic builds a full transaction by issuing these events one after another. For each event it waits for the one-cycle `done` pulse, or polls `busy`, before it issues the next.

Both bus lines are open-drain. A high output enable pulls the line low, and a low output enable releases it so an external pull-up lifts it high. After each transmitted byte the block samples the slave's acknowledge bit. After each received byte it drives ACK or NACK as the command selects. A command that arrives while an event is still running is dropped. The running event continues unchanged, and a sticky collision flag is raised. That flag stays set until it is cleared.

Top module: `i2c_byte_master`

## Requirements
- R1: A valid command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until the event ends. `done` is high for exactly one cycle, the cycle in which `busy` falls.
- R2: Each event is a sequence of half-periods. Each half-period lasts `half_reload`+1 clocks, and `half_reload` is latched when the command is accepted (minimum value 1). The number of half-periods is: Start 2, Repeated Start 4, Stop 3, transmit 18, receive 16, acknowledge 2.
- R3: After reset both output enables are low (bus idle). Start first pulls SDA low while SCL is released. It then pulls SCL low, with SDA still low.
- R4: Repeated Start takes four half-periods. It first releases SDA with SCL low, then releases SCL, then pulls SDA low with SCL released, and finally pulls SCL low.
- R5: Stop takes three half-periods. It first pulls SDA low with SCL low, then releases SCL, then releases SDA. After Stop both lines remain released.
- R6: Transmit sends `cmd_tx_byte` MSB first, as nine clock pulses. Each pulse is an SCL-low half-period followed by an SCL-released half-period. SDA takes a new bit value only one clock after SCL has gone low. On the ninth pulse SDA is released.
- R7: At the end of the ninth released half-period of a transmit event, the level on `sda_in` is captured into `slave_nack`: 0 means ACK and 1 means NACK. The captured value is visible from the `done` cycle onward.
- R8: Receive keeps SDA released for eight pulses. It samples `sda_in` at the end of each SCL-released half-period and shifts the bits MSB first into `rx_byte`, which is complete from the `done` cycle.
- R9: The acknowledge event is one pulse. SDA is pulled low when `cmd_nack` was 0 at acceptance, and released when it was 1. SDA changes one clock after SCL goes low.
- R10: At the end of a transmit, receive or acknowledge event, SCL is pulled low and SDA keeps its last value. Both hold until the next event.
- R11: A command presented while `busy` is high is not accepted, and `wcol` is set on the next edge. The running event's waveform and length are unaffected.
- R12: `wcol` stays set until `wcol_clear` is high at a clock edge. When a collision and a clear occur on the same edge, the set wins.
- R13: Command codes are Start=1, Repeated Start=2, Stop=3, transmit=4, receive=5, acknowledge=6. Codes 0 and 7 are ignored and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_reload | input | RLD_W | Half-period length minus one, in clocks |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Event select (see R13) |
| cmd_tx_byte | input | 8 | Byte to send for a transmit command |
| cmd_nack | input | 1 | For acknowledge command: 1 sends NACK, 0 sends ACK |
| wcol_clear | input | 1 | Clears the collision flag |
| sda_in | input | 1 | Resolved level of the SDA line |
| scl_oe | output | 1 | High pulls SCL low |
| sda_oe | output | 1 | High pulls SDA low |
| busy | output | 1 | An event is running |
| done | output | 1 | One-cycle end-of-event pulse |
| rx_byte | output | 8 | Last received byte |
| slave_nack | output | 1 | Acknowledge bit sampled after the last transmit |
| wcol | output | 1 | Sticky command-collision flag |

## Verification
Several properties are checked on every cycle. `done` is a single cycle that coincides with `busy` falling. A command that collides with a running event sets `wcol` and leaves the running event's type alone. `wcol` persists until it is cleared. SCL is never released for more than two half-periods inside an event. During byte, receive and acknowledge events SDA moves only while SCL has been low for at least a clock. The bench's per-cycle reference model adds what only scenarios can show: the exact waveform and length of each event type across several divider settings, the MSB-first bit order, acknowledge capture with both ACK and NACK slaves, received data from a slave model, set-over-clear priority for the flag, and the idle behaviour of unused codes.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_START  = 3'd1,
        EV_RSTART = 3'd2,
        EV_STOP   = 3'd3,
        EV_TX     = 3'd4,
        EV_RX     = 3'd5,
        EV_ACK    = 3'd6,
        EV_BAD    = 3'd7
    } ev_t;

    localparam int HALF_W = 5;

    // Requested line state for one half-period (1 = pull low)
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

    function automatic logic is_valid_ev(ev_t e);
        return (e != EV_NONE) && (e != EV_BAD);
    endfunction

    // Events made of clock pulses whose data bit is applied after SCL falls
    function automatic logic is_byte_ev(ev_t e);
        return (e == EV_TX) || (e == EV_RX) || (e == EV_ACK);
    endfunction

    function automatic logic [HALF_W-1:0] last_half(ev_t e);
        case (e)
            EV_START:  return 5'd1;
            EV_RSTART: return 5'd3;
            EV_STOP:   return 5'd2;
            EV_TX:     return 5'd17;
            EV_RX:     return 5'd15;
            EV_ACK:    return 5'd1;
            default:   return 5'd0;
        endcase
    endfunction

    function automatic pins_t half_pins(ev_t e, logic [HALF_W-1:0] k,
                                        logic [7:0] tx, logic nack);
        pins_t p;
        logic [3:0] b;
        p = '0;
        b = k[4:1];
        case (e)
            EV_START: begin
                p.scl_low = (k == 5'd1);
                p.sda_low = 1'b1;
            end
            EV_RSTART: begin
                p.scl_low = (k == 5'd0) || (k == 5'd3);
                p.sda_low = (k >= 5'd2);
            end
            EV_STOP: begin
                p.scl_low = (k == 5'd0);
                p.sda_low = (k <= 5'd1);
            end
            EV_TX: begin
                p.scl_low = ~k[0];
                p.sda_low = (b < 4'd8) ? ~tx[3'd7 - b[2:0]] : 1'b0;
            end
            EV_RX: begin
                p.scl_low = ~k[0];
                p.sda_low = 1'b0;
            end
            EV_ACK: begin
                p.scl_low = ~k[0];
                p.sda_low = ~nack;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2cm_baud.sv
module i2cm_baud #(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [RLD_W-1:0] reload,
    output logic             tick,
    output logic [RLD_W-1:0] reload_q
);
    logic [RLD_W-1:0] cnt;

    assign tick = run && (cnt == reload_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            reload_q <= '0;
        end else if (start) begin
            cnt      <= '0;
            reload_q <= reload;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cm_shift.sv
module i2cm_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] tx_in,
    input  logic       sample_rx,
    input  logic       sample_ack,
    input  logic       sda_in,
    output logic [7:0] tx_q,
    output logic [7:0] rx_q,
    output logic       nack_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            nack_q <= 1'b0;
        end else begin
            if (load)       tx_q   <= tx_in;
            if (sample_rx)  rx_q   <= {rx_q[6:0], sda_in};
            if (sample_ack) nack_q <= sda_in;
        end
    end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic [7:0] cmd_tx_byte,
    input  logic       cmd_nack,
    input  logic       wcol_clear,
    input  logic       tick,
    input  logic [7:0] tx_q,
    output logic       accept,
    output logic       active,
    output logic       done,
    output logic       wcol,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       sample_rx,
    output logic       sample_ack,
    output ev_t        ev_q
);
    ev_t              code_in;
    logic [HALF_W-1:0] k_q;
    logic [HALF_W-1:0] k_nxt;
    logic             nack_q;
    logic             defer_q;
    logic             pend_q;
    logic             at_last;
    pins_t            p_first;
    pins_t            p_next;

    always_comb begin
        code_in = ev_t'(cmd_code);
        k_nxt   = k_q + 1'b1;
        at_last = (k_q == last_half(ev_q));
        accept  = cmd_valid && !active && is_valid_ev(code_in);
        p_first = half_pins(code_in, '0, cmd_tx_byte, cmd_nack);
        p_next  = half_pins(ev_q, k_nxt, tx_q, nack_q);
        sample_rx  = active && tick && (ev_q == EV_RX) && k_q[0];
        sample_ack = active && tick && (ev_q == EV_TX) && at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            done    <= 1'b0;
            wcol    <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            ev_q    <= EV_NONE;
            k_q     <= '0;
            nack_q  <= 1'b0;
            defer_q <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            done    <= 1'b0;
            defer_q <= 1'b0;
            if (defer_q) sda_oe <= pend_q;

            if (wcol_clear)         wcol <= 1'b0;
            if (cmd_valid && active) wcol <= 1'b1;

            if (accept) begin
                active <= 1'b1;
                ev_q   <= code_in;
                k_q    <= '0;
                nack_q <= cmd_nack;
                scl_oe <= p_first.scl_low;
                if (is_byte_ev(code_in)) begin
                    pend_q  <= p_first.sda_low;
                    defer_q <= 1'b1;
                end else begin
                    sda_oe <= p_first.sda_low;
                end
            end else if (active && tick) begin
                if (at_last) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    if (is_byte_ev(ev_q)) scl_oe <= 1'b1;
                end else begin
                    k_q    <= k_nxt;
                    scl_oe <= p_next.scl_low;
                    if (is_byte_ev(ev_q) && !k_nxt[0]) begin
                        pend_q  <= p_next.sda_low;
                        defer_q <= 1'b1;
                    end else begin
                        sda_oe <= p_next.sda_low;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int RLD_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RLD_W-1:0] half_reload,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [7:0]       cmd_tx_byte,
    input  logic             cmd_nack,
    input  logic             wcol_clear,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx_byte,
    output logic             slave_nack,
    output logic             wcol
);
    logic             accept;
    logic             tick;
    logic             sample_rx;
    logic             sample_ack;
    logic [7:0]       tx_q;
    logic [RLD_W-1:0] reload_q;
    ev_t              ev_q;
    logic [2:0]       cur_ev;

    assign cur_ev = ev_q;

    i2cm_baud #(.RLD_W(RLD_W)) u_baud (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .run      (busy),
        .reload   (half_reload),
        .tick     (tick),
        .reload_q (reload_q)
    );

    i2cm_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .tx_in      (cmd_tx_byte),
        .sample_rx  (sample_rx),
        .sample_ack (sample_ack),
        .sda_in     (sda_in),
        .tx_q       (tx_q),
        .rx_q       (rx_byte),
        .nack_q     (slave_nack)
    );

    i2cm_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .cmd_tx_byte (cmd_tx_byte),
        .cmd_nack    (cmd_nack),
        .wcol_clear  (wcol_clear),
        .tick        (tick),
        .tx_q        (tx_q),
        .accept      (accept),
        .active      (busy),
        .done        (done),
        .wcol        (wcol),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .sample_rx   (sample_rx),
        .sample_ack  (sample_ack),
        .ev_q        (ev_q)
    );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker #(
    parameter int RLD_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             wcol_clear,
    input logic             busy,
    input logic             done,
    input logic             wcol,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic [2:0]       cur_ev,
    input logic [RLD_W-1:0] reload_q
);
    logic [RLD_W+1:0] rel_cnt;
    logic             byte_ev;

    assign byte_ev = (cur_ev == 3'd4) || (cur_ev == 3'd5) || (cur_ev == 3'd6);

    always_ff @(posedge clk) begin
        if (rst || !busy || scl_oe) rel_cnt <= '0;
        else                        rel_cnt <= rel_cnt + 1'b1;
    end

    a_r1_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r1_fall_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r1_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r2_high_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> ({2'b00, rel_cnt} <= 2 * ({4'b0, reload_q} + 1)));

    a_r6_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && byte_ev && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

    a_r11_wcol_set: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> wcol);

    a_r11_event_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> $stable(cur_ev));

    a_r12_wcol_hold: assert property (@(posedge clk) disable iff (rst)
        (wcol && !wcol_clear) |=> wcol);
endmodule

bind i2c_byte_master i2cm_checker #(.RLD_W(RLD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .wcol_clear (wcol_clear),
    .busy       (busy),
    .done       (done),
    .wcol       (wcol),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .cur_ev     (cur_ev),
    .reload_q   (reload_q)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [RW-1:0] half_reload = 12'd2;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = 3'd0;
    logic [7:0]    cmd_tx_byte = 8'd0;
    logic          cmd_nack = 1'b0;
    logic          wcol_clear = 1'b0;
    logic          sda_in;
    logic          scl_oe, sda_oe, busy, done, slave_nack, wcol;
    logic [7:0]    rx_byte;

    typedef struct {
        bit scl;
        bit sda;
        bit busy;
        bit done;
        bit slv;
        int tag;
        int ev;
    } ent_t;

    ent_t q[$];
    ent_t cur = '{scl:0, sda:0, busy:0, done:0, slv:0, tag:3, ev:0};
    bit   m_sda = 0;
    bit   exp_wcol = 0;
    bit   pend_set = 0;
    bit   pend_clr = 0;
    logic [7:0] exp_rx = 8'd0;
    bit   exp_nack = 0;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    always #4 clk = ~clk;

    assign sda_in = ~(sda_oe | cur.slv);

    i2c_byte_master #(.RLD_W(RW)) uut (
        .clk(clk), .rst(rst), .half_reload(half_reload), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_tx_byte(cmd_tx_byte), .cmd_nack(cmd_nack),
        .wcol_clear(wcol_clear), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .done(done), .rx_byte(rx_byte), .slave_nack(slave_nack), .wcol(wcol)
    );

    function automatic string tag_name(int t);
        case (t)
            3:  return "R3";
            4:  return "R4";
            5:  return "R5";
            6:  return "R6";
            8:  return "R8";
            9:  return "R9";
            10: return "R10";
            13: return "R13";
            default: return "R1";
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual busy=%0b expected 0", busy);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (q.size() > 0) cur = q.pop_front();
        else begin
            cur.busy = 0; cur.done = 0; cur.slv = 0;
            if (cur.tag != 13) cur.tag = 10;
        end
        if (pend_set) exp_wcol = 1;
        else if (pend_clr) exp_wcol = 0;
        pend_set = 0; pend_clr = 0;
        chk(scl_oe == cur.scl, {tag_name(cur.tag), " (half timing R2)"}, "scl_oe", scl_oe, cur.scl);
        chk(sda_oe == cur.sda, {tag_name(cur.tag), " (half timing R2)"}, "sda_oe", sda_oe, cur.sda);
        chk(busy == cur.busy, "R1", "busy", busy, cur.busy);
        chk(done == cur.done, "R1", "done", done, cur.done);
        chk(wcol == exp_wcol, "R11/R12", "wcol", wcol, exp_wcol);
        if (cur.done && cur.ev == 4)
            chk(slave_nack == exp_nack, "R7", "slave_nack", slave_nack, exp_nack);
        if (cur.done && cur.ev == 5)
            chk(rx_byte == exp_rx, "R8", "rx_byte", rx_byte, exp_rx);
    endtask

    // Expected per-cycle bus waveform, derived from the requirement text
    task automatic push_ev(input int code, input logic [7:0] tx, input bit nack,
                           input bit snack, input logic [7:0] sb);
        int h;
        int n;
        bit byteev;
        bit s_scl;
        bit s_sda;
        bit slv;
        ent_t e;
        h = int'(half_reload) + 1;
        byteev = (code >= 4);
        case (code)
            1: n = 2;
            2: n = 4;
            3: n = 3;
            4: n = 18;
            5: n = 16;
            default: n = 2;
        endcase
        for (int k = 0; k < n; k++) begin
            int b;
            b = k / 2;
            case (code)
                1: begin s_scl = (k == 1); s_sda = 1; end
                2: begin s_scl = (k == 0) || (k == 3); s_sda = (k >= 2); end
                3: begin s_scl = (k == 0); s_sda = (k <= 1); end
                4: begin s_scl = (k % 2 == 0); s_sda = (b < 8) ? !tx[7-b] : 1'b0; end
                5: begin s_scl = (k % 2 == 0); s_sda = 0; end
                default: begin s_scl = (k % 2 == 0); s_sda = !nack; end
            endcase
            if (code == 4 && b == 8) slv = !snack;
            else if (code == 5)      slv = !sb[7-b];
            else                     slv = 0;
            for (int c = 0; c < h; c++) begin
                e.scl  = s_scl;
                e.sda  = (byteev && (k % 2 == 0) && c == 0) ? m_sda : s_sda;
                e.busy = 1; e.done = 0; e.slv = slv; e.ev = code;
                case (code)
                    1: e.tag = 3;  2: e.tag = 4;  3: e.tag = 5;
                    4: e.tag = 6;  5: e.tag = 8;  default: e.tag = 9;
                endcase
                q.push_back(e);
            end
            m_sda = s_sda;
        end
        e.scl  = byteev ? 1'b1 : s_scl;
        e.sda  = m_sda;
        e.busy = 0; e.done = 1; e.slv = 0; e.tag = 10; e.ev = code;
        q.push_back(e);
        if (code == 4) exp_nack = snack;
        if (code == 5) exp_rx = sb;
    endtask

    task automatic issue(input int code, input logic [7:0] tx, input bit nack,
                         input bit snack, input logic [7:0] sb, input bit clr);
        cmd_valid = 1; cmd_code = 3'(code); cmd_tx_byte = tx; cmd_nack = nack;
        wcol_clear = clr;
        if (clr) pend_clr = 1;
        if (cur.busy) pend_set = 1;           // R11: rejected, flagged
        else if (code >= 1 && code <= 6) push_ev(code, tx, nack, snack, sb);
        else cur.tag = 13;                    // R13: ignored code
        step();
        cmd_valid = 0; wcol_clear = 0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) step();
        step();
    endtask

    task automatic clear_wcol();
        wcol_clear = 1; pend_clr = 1;
        step();
        wcol_clear = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        step();                                  // R3 idle after reset
        // R3 Start, with a colliding transmit (R11)
        issue(1, 8'h00, 0, 0, 8'h00, 0);
        issue(4, 8'hFF, 0, 0, 8'h00, 0);
        wait_idle();
        clear_wcol();                            // R12 clear
        // R6/R7 transmit with ACK; collision and clear on one edge (R12 set wins)
        issue(4, 8'hA6, 0, 0, 8'h00, 0);
        step();
        issue(2, 8'h00, 0, 0, 8'h00, 1);
        repeat (4) step();                       // R12 flag held
        wait_idle();
        clear_wcol();
        // R7 transmit with NACK
        issue(4, 8'h5B, 0, 1, 8'h00, 0);
        wait_idle();
        half_reload = 12'd1;
        issue(2, 8'h00, 0, 0, 8'h00, 0);         // R4
        wait_idle();
        issue(4, 8'hA1, 0, 0, 8'h00, 0);
        wait_idle();
        issue(5, 8'h00, 0, 0, 8'h3C, 0);         // R8
        wait_idle();
        issue(6, 8'h00, 0, 0, 8'h00, 0);         // R9 ACK
        wait_idle();
        half_reload = 12'd3;
        issue(5, 8'h00, 0, 0, 8'hC5, 0);
        wait_idle();
        issue(6, 8'h00, 1, 0, 8'h00, 0);         // R9 NACK
        wait_idle();
        issue(7, 8'h00, 0, 0, 8'h00, 0);         // R13
        repeat (3) step();                       // R10 held state
        issue(3, 8'h00, 0, 0, 8'h00, 0);         // R5
        wait_idle();
        issue(0, 8'h00, 0, 0, 8'h00, 0);         // R13
        repeat (3) step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule